// File: doc/BRIEF.md
# Debug Monitor Entry Sequencer

This block takes a microcontroller into its serial debug monitor. Entry happens in two ways. The first is the clock edge on which reset is released while the mode strap reads high. The second is a software-interrupt request raised while the part runs normally. On entry the block moves through a fixed handshake. It accepts exactly eight security bytes from a byte-receive interface and compares each one against a reference key. It then holds the serial transmit line low for ten baud periods to tell the host it may talk. After that it raises a ready-for-command flag.

While the monitor is active, the block changes three other things. It rewrites the high byte of interrupt vector fetches from 0xFF to 0xFE, so the monitor firmware's vectors are used. It holds the watchdog off if a high-voltage condition was seen on the interrupt or reset pin at reset release. It reports whether the bus clock skips the divide-by-two stage, based on a clock strap read at entry.

Top module: `dbgmon_entry`

## Requirements
- R1: On the first clock edge with `rst` low after reset, if `mode_strap` is 1, `mon_active` is 1 from that edge on. If `mode_strap` is 0, `mon_active` stays 0.
- R2: A `swi_req` pulse while `mon_active` is 0 and reset is over sets `mon_active` at that clock edge.
- R3: In the security phase the block accepts exactly eight bytes on `rx_valid`. Byte k (k = 0 for the first byte) is compared with `SEC_KEY[8k+7:8k]`. `sec_done` rises at the edge that takes the eighth byte. `sec_pass` is 1 only if all eight bytes matched, and the break follows in either case.
- R4: `tx_bit` goes low at the edge that takes the eighth security byte. It stays low until the tenth `baud_tick` has been counted during the break, and it goes high again at that edge.
- R5: `cmd_ready` rises at the same edge at which `tx_bit` returns high after the break. It stays 1 until reset.
- R6: Bytes received before the security phase starts, or while the break is on the line, are not counted or compared. Such bytes change neither `sec_done`, `sec_pass` nor `tx_bit`.
- R7: While `mon_active` and `vec_fetch` are both 1, an address of the form 0xFFxx on `vec_addr_in` leaves on `vec_addr_out` as 0xFExx. In every other case the address passes through unchanged.
- R8: `wdog_en` is 0 only while `mon_active` is 1 and `hv_irq` or `hv_rst` was 1 at the reset-release edge. Otherwise it is 1.
- R9: `clk_div_bypass` is 1 only while `mon_active` is 1 and `clk_strap` was 0 at the monitor-entry edge.
- R10: During reset, `mon_active`, `cmd_ready`, `sec_done`, `sec_pass` and `clk_div_bypass` are 0, while `tx_bit` and `wdog_en` are 1.
- R11: Changes on `mode_strap`, `hv_irq`, `hv_rst` and `clk_strap` after the edge that sampled them have no effect on the outputs until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_strap | input | 1 | Mode strap conditions met |
| clk_strap | input | 1 | Clock strap; low selects divider bypass |
| hv_irq | input | 1 | High voltage present on interrupt pin |
| hv_rst | input | 1 | High voltage present on reset pin |
| swi_req | input | 1 | Software-interrupt monitor entry request |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| baud_tick | input | 1 | One pulse per serial bit period |
| vec_fetch | input | 1 | Current access is a vector fetch |
| vec_addr_in | input | 16 | Vector address from the CPU |
| vec_addr_out | output | 16 | Vector address after remapping |
| tx_bit | output | 1 | Serial transmit line |
| cmd_ready | output | 1 | Monitor ready for commands |
| sec_done | output | 1 | Eight security bytes received |
| sec_pass | output | 1 | All security bytes matched |
| mon_active | output | 1 | Monitor mode active |
| wdog_en | output | 1 | Watchdog enable |
| clk_div_bypass | output | 1 | Bus clock bypasses divide-by-two |

## Verification
The bench checks the byte boundary around the eighth security byte. A counter that is off by one would raise `sec_done` or pull the line low after seven bytes, or would still be waiting after eight. It also checks the tenth break tick. Ending the break one tick early or late leaves `tx_bit` and `cmd_ready` wrong after the ninth or tenth tick. Further cases are bytes sent while idle or during the break, which a careless design would count or compare, and strap and high-voltage inputs changed after release, which a design that does not latch them would follow. Finally it covers a software-interrupt entry with one wrong key byte, where the break must still go out and `sec_pass` must stay low.

// File: rtl/dbgmon_pkg.sv
package dbgmon_pkg;

    typedef enum logic [1:0] {
        MS_IDLE   = 2'd0,
        MS_SECURE = 2'd1,
        MS_BREAK  = 2'd2,
        MS_READY  = 2'd3
    } mon_state_e;

    typedef struct packed {
        logic mode;
        logic hv_any;
        logic clk_lo;
    } strap_t;

    localparam logic [7:0] NORMAL_VEC_PAGE  = 8'hFF;
    localparam logic [7:0] MONITOR_VEC_PAGE = 8'hFE;

    function automatic logic [15:0] remap_vector(input logic [15:0] addr, input logic en);
        logic [15:0] res;
        res = addr;
        if (en && addr[15:8] == NORMAL_VEC_PAGE)
            res[15:8] = MONITOR_VEC_PAGE;
        return res;
    endfunction

endpackage

// File: rtl/dbgmon_strap_capture.sv
module dbgmon_strap_capture
    import dbgmon_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   mode_strap,
    input  logic   clk_strap,
    input  logic   hv_irq,
    input  logic   hv_rst,
    input  logic   entry_evt,
    output logic   release_evt,
    output strap_t straps
);
    logic   in_reset_q;
    strap_t straps_q;

    assign release_evt = in_reset_q && !rst;
    assign straps      = straps_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_reset_q <= 1'b1;
            straps_q   <= '0;
        end else begin
            in_reset_q <= 1'b0;
            if (release_evt) begin
                straps_q.mode   <= mode_strap;
                straps_q.hv_any <= hv_irq | hv_rst;
            end
            if (entry_evt)
                straps_q.clk_lo <= !clk_strap;
        end
    end
endmodule

// File: rtl/dbgmon_sec_check.sv
module dbgmon_sec_check #(
    parameter int          SEC_BYTES = 8,
    parameter logic [63:0] SEC_KEY   = 64'h0123_4567_89AB_CDEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    output logic       last_byte,
    output logic       done,
    output logic       pass
);
    localparam int IW = (SEC_BYTES > 1) ? $clog2(SEC_BYTES) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(SEC_BYTES - 1);

    logic [IW-1:0] idx_q;
    logic          mismatch_q;
    logic          done_q;
    logic          take;
    logic [7:0]    ref_byte;

    assign take      = enable && rx_valid && !done_q;
    assign last_byte = take && (idx_q == LAST_IDX);
    assign ref_byte  = SEC_KEY[8*idx_q +: 8];
    assign done      = done_q;
    assign pass      = done_q && !mismatch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q      <= '0;
            mismatch_q <= 1'b0;
            done_q     <= 1'b0;
        end else if (take) begin
            if (rx_byte != ref_byte)
                mismatch_q <= 1'b1;
            if (last_byte)
                done_q <= 1'b1;
            else
                idx_q <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/dbgmon_break_gen.sv
module dbgmon_break_gen #(
    parameter int BREAK_BITS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic baud_tick,
    output logic finished
);
    localparam int CW = $clog2(BREAK_BITS + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(BREAK_BITS - 1);

    logic [CW-1:0] cnt_q;

    assign finished = active && baud_tick && (cnt_q == LAST_CNT);

    always_ff @(posedge clk) begin
        if (rst || !active)
            cnt_q <= '0;
        else if (baud_tick)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/dbgmon_entry.sv
module dbgmon_entry
    import dbgmon_pkg::*;
#(
    parameter int          SEC_BYTES  = 8,
    parameter int          BREAK_BITS = 10,
    parameter logic [63:0] SEC_KEY    = 64'h0123_4567_89AB_CDEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mode_strap,
    input  logic        clk_strap,
    input  logic        hv_irq,
    input  logic        hv_rst,
    input  logic        swi_req,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        baud_tick,
    input  logic        vec_fetch,
    input  logic [15:0] vec_addr_in,
    output logic [15:0] vec_addr_out,
    output logic        tx_bit,
    output logic        cmd_ready,
    output logic        sec_done,
    output logic        sec_pass,
    output logic        mon_active,
    output logic        wdog_en,
    output logic        clk_div_bypass
);
    mon_state_e state_q, state_d;
    strap_t     straps;
    logic       release_evt;
    logic       entry_evt;
    logic       last_byte;
    logic       break_end;

    // entry: strap-qualified reset release, or software request while idle
    assign entry_evt = (release_evt && mode_strap) ||
                       (state_q == MS_IDLE && !release_evt && swi_req && !rst);

    dbgmon_strap_capture u_cap (
        .clk         (clk),
        .rst         (rst),
        .mode_strap  (mode_strap),
        .clk_strap   (clk_strap),
        .hv_irq      (hv_irq),
        .hv_rst      (hv_rst),
        .entry_evt   (entry_evt),
        .release_evt (release_evt),
        .straps      (straps)
    );

    dbgmon_sec_check #(
        .SEC_BYTES (SEC_BYTES),
        .SEC_KEY   (SEC_KEY)
    ) u_sec (
        .clk       (clk),
        .rst       (rst),
        .enable    (state_q == MS_SECURE),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .last_byte (last_byte),
        .done      (sec_done),
        .pass      (sec_pass)
    );

    dbgmon_break_gen #(
        .BREAK_BITS (BREAK_BITS)
    ) u_brk (
        .clk       (clk),
        .rst       (rst),
        .active    (state_q == MS_BREAK),
        .baud_tick (baud_tick),
        .finished  (break_end)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_IDLE:   if (entry_evt) state_d = MS_SECURE;
            MS_SECURE: if (last_byte) state_d = MS_BREAK;
            MS_BREAK:  if (break_end) state_d = MS_READY;
            MS_READY:  state_d = MS_READY;
            default:   state_d = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= MS_IDLE;
        else     state_q <= state_d;
    end

    assign mon_active     = (state_q != MS_IDLE);
    assign tx_bit         = (state_q != MS_BREAK);
    assign cmd_ready      = (state_q == MS_READY);
    assign wdog_en        = !(mon_active && straps.hv_any);
    assign clk_div_bypass = mon_active && straps.clk_lo;
    assign vec_addr_out   = remap_vector(vec_addr_in, mon_active && vec_fetch);
endmodule

// File: rtl/dbgmon_entry_chk.sv
module dbgmon_entry_chk (
    input logic        clk,
    input logic        rst,
    input logic        baud_tick,
    input logic        vec_fetch,
    input logic [15:0] vec_addr_in,
    input logic [15:0] vec_addr_out,
    input logic        tx_bit,
    input logic        cmd_ready,
    input logic        sec_done,
    input logic        mon_active,
    input logic        wdog_en
);
    p_break_after_sec_r4: assert property (@(posedge clk) disable iff (rst)
        !tx_bit |-> sec_done);

    p_ready_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_ready) |-> $past(baud_tick) && tx_bit);

    p_ready_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |=> cmd_ready);

    p_done_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        sec_done |=> sec_done);

    p_done_needs_mon_r3: assert property (@(posedge clk) disable iff (rst)
        sec_done |-> mon_active);

    p_pass_thru_r7: assert property (@(posedge clk) disable iff (rst)
        !(mon_active && vec_fetch) |-> vec_addr_out == vec_addr_in);

    p_low_byte_r7: assert property (@(posedge clk) disable iff (rst)
        vec_addr_out[7:0] == vec_addr_in[7:0]);

    p_wdog_normal_r8: assert property (@(posedge clk) disable iff (rst)
        !mon_active |-> wdog_en);
endmodule

bind dbgmon_entry dbgmon_entry_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .baud_tick    (baud_tick),
    .vec_fetch    (vec_fetch),
    .vec_addr_in  (vec_addr_in),
    .vec_addr_out (vec_addr_out),
    .tx_bit       (tx_bit),
    .cmd_ready    (cmd_ready),
    .sec_done     (sec_done),
    .mon_active   (mon_active),
    .wdog_en      (wdog_en)
);

// File: tb/dbgmon_entry_bench.sv
module dbgmon_entry_bench;
    localparam logic [63:0] KEY = 64'h1122_3344_5566_7788;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_strap = 1'b0, clk_strap = 1'b1, hv_irq = 1'b0, hv_rst = 1'b0;
    logic        swi_req = 1'b0, rx_valid = 1'b0, baud_tick = 1'b0, vec_fetch = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic [15:0] vec_addr_in = 16'h0000;
    logic [15:0] vec_addr_out;
    logic        tx_bit, cmd_ready, sec_done, sec_pass, mon_active, wdog_en, clk_div_bypass;

    always #2.5 clk = ~clk;

    dbgmon_entry #(.SEC_KEY(KEY)) u_dbgmon_entry (
        .clk(clk), .rst(rst), .mode_strap(mode_strap), .clk_strap(clk_strap),
        .hv_irq(hv_irq), .hv_rst(hv_rst), .swi_req(swi_req), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .baud_tick(baud_tick), .vec_fetch(vec_fetch),
        .vec_addr_in(vec_addr_in), .vec_addr_out(vec_addr_out), .tx_bit(tx_bit),
        .cmd_ready(cmd_ready), .sec_done(sec_done), .sec_pass(sec_pass),
        .mon_active(mon_active), .wdog_en(wdog_en), .clk_div_bypass(clk_div_bypass)
    );

    typedef enum int {K_MON, K_TX, K_RDY, K_DONE, K_PASS, K_WDOG, K_BYP, K_VEC} kind_e;
    typedef struct {
        kind_e kind;
        int    exp;
        string req;
    } item_t;

    item_t exp_q[$];
    int    n_run = 0, n_fail = 0;
    bit    finished = 1'b0;
    event  do_cmp, cmp_done;

    function automatic int actual_of(kind_e k);
        case (k)
            K_MON:  return int'(mon_active);
            K_TX:   return int'(tx_bit);
            K_RDY:  return int'(cmd_ready);
            K_DONE: return int'(sec_done);
            K_PASS: return int'(sec_pass);
            K_WDOG: return int'(wdog_en);
            K_BYP:  return int'(clk_div_bypass);
            default: return int'(vec_addr_out);
        endcase
    endfunction

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(do_cmp);
            while (exp_q.size() > 0) begin
                item_t it;
                int    act;
                it  = exp_q.pop_front();
                act = actual_of(it.kind);
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s %s: actual %0h expected %0h", it.req, it.kind.name(), act, it.exp);
                end
            end
            ->cmp_done;
        end
    end

    task automatic push(kind_e k, int v, string r);
        item_t it;
        it.kind = k; it.exp = v; it.req = r;
        exp_q.push_back(it);
    endtask

    task automatic compare();
        ->do_cmp;
        @(cmp_done);
    endtask

    task automatic send_byte(logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic tick();
        baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        // ---------- scenario A: strap entry, correct key ----------
        mode_strap = 1'b1; clk_strap = 1'b0; hv_irq = 1'b1; hv_rst = 1'b0;
        do_reset();
        push(K_MON, 0, "R10"); push(K_TX, 1, "R10"); push(K_RDY, 0, "R10");
        push(K_DONE, 0, "R10"); push(K_PASS, 0, "R10"); push(K_WDOG, 1, "R10");
        push(K_BYP, 0, "R10");
        compare();
        rst = 1'b0;
        @(negedge clk);
        push(K_MON, 1, "R1"); push(K_WDOG, 0, "R8"); push(K_BYP, 1, "R9");
        compare();
        // R11: straps move after release
        hv_irq = 1'b0; clk_strap = 1'b1; mode_strap = 1'b0;
        @(negedge clk);
        push(K_MON, 1, "R11"); push(K_WDOG, 0, "R11"); push(K_BYP, 1, "R11");
        compare();
        vec_fetch = 1'b1; vec_addr_in = 16'hFFFE; #0.1;
        push(K_VEC, 'hFEFE, "R7"); compare();
        vec_addr_in = 16'hFFFC; #0.1;
        push(K_VEC, 'hFEFC, "R7"); compare();
        vec_addr_in = 16'h12FE; #0.1;
        push(K_VEC, 'h12FE, "R7"); compare();
        vec_fetch = 1'b0; vec_addr_in = 16'hFFFE; #0.1;
        push(K_VEC, 'hFFFE, "R7"); compare();
        for (int k = 0; k < 7; k++) send_byte(KEY[8*k +: 8]);
        push(K_DONE, 0, "R3"); push(K_TX, 1, "R4"); compare();
        send_byte(KEY[63:56]);
        push(K_DONE, 1, "R3"); push(K_PASS, 1, "R3"); push(K_TX, 0, "R4");
        push(K_RDY, 0, "R5"); compare();
        // R6: wrong bytes during the break
        for (int k = 0; k < 3; k++) send_byte(8'h00);
        push(K_PASS, 1, "R6"); push(K_TX, 0, "R6"); compare();
        for (int k = 0; k < 9; k++) tick();
        push(K_TX, 0, "R4"); push(K_RDY, 0, "R5"); compare();
        tick();
        push(K_TX, 1, "R4"); push(K_RDY, 1, "R5"); compare();
        for (int k = 0; k < 4; k++) tick();
        push(K_RDY, 1, "R5"); push(K_TX, 1, "R5"); compare();

        // ---------- scenario B: no strap, SWI entry, bad key ----------
        mode_strap = 1'b0; clk_strap = 1'b0; hv_irq = 1'b0; hv_rst = 1'b1;
        do_reset();
        rst = 1'b0;
        @(negedge clk);
        push(K_MON, 0, "R1"); push(K_WDOG, 1, "R8"); push(K_BYP, 0, "R9");
        compare();
        vec_fetch = 1'b1; vec_addr_in = 16'hFFFE; #0.1;
        push(K_VEC, 'hFFFE, "R7"); compare();
        vec_fetch = 1'b0;
        hv_rst = 1'b0;
        // R6: bytes before the security phase
        for (int k = 0; k < 8; k++) send_byte(KEY[8*k +: 8]);
        push(K_DONE, 0, "R6"); push(K_TX, 1, "R6"); push(K_MON, 0, "R6"); compare();
        clk_strap = 1'b1;
        swi_req = 1'b1;
        @(negedge clk);
        swi_req = 1'b0;
        push(K_MON, 1, "R2"); push(K_BYP, 0, "R9"); push(K_WDOG, 0, "R8"); compare();
        for (int k = 0; k < 8; k++) send_byte((k == 5) ? 8'hA5 : KEY[8*k +: 8]);
        push(K_DONE, 1, "R3"); push(K_PASS, 0, "R3"); push(K_TX, 0, "R4"); compare();
        for (int k = 0; k < 10; k++) tick();
        push(K_TX, 1, "R4"); push(K_RDY, 1, "R5"); push(K_PASS, 0, "R3"); compare();

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule